// File: doc/BRIEF.md
# Measurement Limit Checker with Sticky Status and Alert

This block watches a stream of measurement results from a multiplexed converter and a set of fan tachometer counters. Each result arrives with a channel number and a valid strobe. The block compares it against that channel's own bounds and keeps one sticky status bit per channel. A maskable alert request drives the enable of an open-drain, active-low interrupt line.

Channels come in three kinds, set by parameters:
- **Voltage channels** come first. Their readings are unsigned, with a low and a high bound.
- **Temperature channels** come next. Their readings are two's complement, with a low and a high bound.
- **Fan channels** come last. Each carries a 16-bit period count. A larger count means a slower fan, so each fan channel has a single slowest-allowed bound.

A status read pulse returns the status vector. It clears only the bits whose channel has since come back within bounds. The alert therefore stays asserted for as long as a fault lasts, and until software has read the status.

Top module: `lim_alert_top`

## Requirements
- R1: A voltage reading (low 8 bits, unsigned) strictly above its high bound or strictly below its low bound sets that channel's status bit. A reading equal to a bound does not set it. Voltage bounds reset to low 0x00 and high 0xFF.
- R2: Temperature readings (low 8 bits) are compared as two's complement. For example, 0xF0 (-16) is within a high bound of 0x10.
- R3: A fan reading sets its status bit when it exceeds the fan's bound, or when it is 0xFFFF (stalled). The second case applies even when the bound is 0xFFFF. The fan bound resets to 0xFFFF.
- R4: After reset:
  - all status bits and all mask bits are 0, and the alert is released;
  - temperature bounds are low 0x81 and high 0x7F, so 0x80 is flagged and 0x81 and 0x7F are not.
- R5: A set status bit stays set when later readings return within bounds, as long as no status read occurs.
- R6: A status read pulse clears every status bit whose most recent reading was within bounds.
- R7: `alert_pull_o` is 1 exactly when some status bit is set whose mask bit is 0.
  - A mask bit of 1 keeps that channel from raising the alert.
  - A mask bit does not change the status bits.
  - Bit i of the mask and of the status corresponds to channel i.
- R8: While a channel's latest reading is out of bounds, a status read leaves its status bit set, so the alert remains asserted.
- R9: A bound write affects only the named channel and the named bound (`lim_hi_i` = 1 selects the high or fan bound). It applies from the next reading of that channel onward.
- R10: A measurement whose channel number is NCH or above changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| meas_vld_i | input | 1 | Measurement valid strobe |
| meas_ch_i | input | CHW | Channel number: voltage, then temperature, then fan |
| meas_val_i | input | DW | Measured value, right-aligned |
| lim_wr_i | input | 1 | Bound write strobe |
| lim_ch_i | input | CHW | Channel whose bound is written |
| lim_hi_i | input | 1 | 1 = high/fan bound, 0 = low bound |
| lim_val_i | input | DW | Bound value, right-aligned |
| msk_wr_i | input | 1 | Mask write strobe |
| msk_val_i | input | NCH | New mask, one bit per channel |
| stat_rd_i | input | 1 | Status read pulse |
| status_o | output | NCH | Sticky status bits, one per channel |
| alert_pull_o | output | 1 | Pull-down enable for the open-drain alert line |

## Verification
The bench goes after the bound edges in both directions:
- **Bound edges.** A reading equal to a bound must not flag. An off-by-one compare would set status on these readings.
- **Signed temperature compare.** A negative temperature is probed against a small positive high bound. An unsigned compare would wrongly flag it.
- **Fan stall at the default bound.** The bench expects a stalled fan to flag with the bound left at 0xFFFF. A plain greater-than test would never flag a stall there.
- **Reads while a fault persists.** A design that clears on every read would drop the alert during a live fault.
- **Reads after recovery.** A design that never clears would keep the alert stuck.
- **Masking.** It must gate only the alert and never the status.
- **Bound writes.** They must stay confined to their own channel.

// File: rtl/lac_pkg.sv
package lac_pkg;

  typedef enum logic [1:0] {
    KIND_VOLT = 2'd0,
    KIND_TEMP = 2'd1,
    KIND_FAN  = 2'd2
  } chan_kind_e;

  // Channel order is fixed: voltage, then temperature, then fan.
  function automatic chan_kind_e kind_of(input int ch, input int nv, input int nt);
    if (ch < nv)           return KIND_VOLT;
    else if (ch < nv + nt) return KIND_TEMP;
    else                   return KIND_FAN;
  endfunction

endpackage

// File: rtl/lac_limits.sv
module lac_limits
  import lac_pkg::*;
#(
  parameter int N_VOLT = 4,
  parameter int N_TEMP = 3,
  parameter int N_FAN  = 2,
  parameter int VOLT_W = 8,
  parameter int TEMP_W = 8,
  parameter int FAN_W  = 16,
  parameter int DW     = 16,
  parameter int NCH    = N_VOLT + N_TEMP + N_FAN,
  parameter int CHW    = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [CHW-1:0] wr_ch_i,
  input  logic           wr_hi_i,
  input  logic [DW-1:0]  wr_val_i,
  input  logic [CHW-1:0] sel_ch_i,
  output logic [DW-1:0]  hi_o,
  output logic [DW-1:0]  lo_o
);

  localparam logic [DW-1:0] VOLT_LO_RST = '0;
  localparam logic [DW-1:0] VOLT_HI_RST = DW'({VOLT_W{1'b1}});
  localparam logic [DW-1:0] TEMP_LO_RST = DW'((1 << (TEMP_W - 1)) + 1);
  localparam logic [DW-1:0] TEMP_HI_RST = DW'((1 << (TEMP_W - 1)) - 1);
  localparam logic [DW-1:0] FAN_RST     = DW'({FAN_W{1'b1}});

  logic [DW-1:0] hi_q [NCH];
  logic [DW-1:0] lo_q [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    localparam chan_kind_e KIND = kind_of(c, N_VOLT, N_TEMP);
    logic hit;
    logic hi_en;
    logic lo_en;

    assign hit   = wr_i && (wr_ch_i == CHW'(c));
    assign hi_en = hit && wr_hi_i;
    assign lo_en = hit && !wr_hi_i;

    if (KIND == KIND_VOLT) begin : g_volt
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          hi_q[c] <= VOLT_HI_RST;
          lo_q[c] <= VOLT_LO_RST;
        end else begin
          if (hi_en) hi_q[c] <= DW'(wr_val_i[VOLT_W-1:0]);
          if (lo_en) lo_q[c] <= DW'(wr_val_i[VOLT_W-1:0]);
        end
      end
    end else if (KIND == KIND_TEMP) begin : g_temp
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          hi_q[c] <= TEMP_HI_RST;
          lo_q[c] <= TEMP_LO_RST;
        end else begin
          if (hi_en) hi_q[c] <= DW'(wr_val_i[TEMP_W-1:0]);
          if (lo_en) lo_q[c] <= DW'(wr_val_i[TEMP_W-1:0]);
        end
      end
    end else begin : g_fan
      // A fan has only a slowest-allowed bound; low-bound writes are dropped.
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          hi_q[c] <= FAN_RST;
        end else if (hi_en) begin
          hi_q[c] <= DW'(wr_val_i[FAN_W-1:0]);
        end
      end
      assign lo_q[c] = '0;
    end
  end

  always_comb begin
    hi_o = '0;
    lo_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (sel_ch_i == CHW'(c)) begin
        hi_o = hi_q[c];
        lo_o = lo_q[c];
      end
    end
  end

endmodule

// File: rtl/lac_compare.sv
module lac_compare
  import lac_pkg::*;
#(
  parameter int VOLT_W = 8,
  parameter int TEMP_W = 8,
  parameter int FAN_W  = 16,
  parameter int DW     = 16
) (
  input  chan_kind_e    kind_i,
  input  logic [DW-1:0] val_i,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] lo_i,
  output logic          oor_o
);

  logic volt_oor;
  logic temp_oor;
  logic fan_oor;

  assign volt_oor = (val_i[VOLT_W-1:0] > hi_i[VOLT_W-1:0]) ||
                    (val_i[VOLT_W-1:0] < lo_i[VOLT_W-1:0]);

  assign temp_oor = ($signed(val_i[TEMP_W-1:0]) > $signed(hi_i[TEMP_W-1:0])) ||
                    ($signed(val_i[TEMP_W-1:0]) < $signed(lo_i[TEMP_W-1:0]));

  // An all-ones count is a stall and is flagged whatever the bound holds.
  assign fan_oor  = (val_i[FAN_W-1:0] > hi_i[FAN_W-1:0]) || (&val_i[FAN_W-1:0]);

  always_comb begin
    unique case (kind_i)
      KIND_VOLT: oor_o = volt_oor;
      KIND_TEMP: oor_o = temp_oor;
      KIND_FAN:  oor_o = fan_oor;
      default:   oor_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/lac_status.sv
module lac_status #(
  parameter int NCH = 9,
  parameter int CHW = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           meas_vld_i,
  input  logic [CHW-1:0] meas_ch_i,
  input  logic           oor_i,
  input  logic           rd_i,
  input  logic           msk_wr_i,
  input  logic [NCH-1:0] msk_val_i,
  output logic [NCH-1:0] status_o,
  output logic [NCH-1:0] fault_o,
  output logic           alert_o
);

  logic [NCH-1:0] status_q, status_d;
  logic [NCH-1:0] fault_q,  fault_d;
  logic [NCH-1:0] mask_q,   mask_d;
  logic [NCH-1:0] set_vec;
  logic [NCH-1:0] clr_vec;
  logic           fault_en;
  logic           status_en;

  always_comb begin
    fault_d = fault_q;
    set_vec = '0;
    for (int c = 0; c < NCH; c++) begin
      if (meas_vld_i && (meas_ch_i == CHW'(c))) begin
        fault_d[c] = oor_i;
        set_vec[c] = oor_i;
      end
    end
    // A read clears only bits whose latest reading is back within bounds.
    clr_vec   = rd_i ? ~fault_d : '0;
    status_d  = (status_q & ~clr_vec) | set_vec;
    mask_d    = msk_val_i;
    fault_en  = meas_vld_i;
    status_en = meas_vld_i || rd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      fault_q  <= '0;
      mask_q   <= '0;
    end else begin
      if (status_en) status_q <= status_d;
      if (fault_en)  fault_q  <= fault_d;
      if (msk_wr_i)  mask_q   <= mask_d;
    end
  end

  assign status_o = status_q;
  assign fault_o  = fault_q;
  assign alert_o  = |(status_q & ~mask_q);

endmodule

// File: rtl/lim_alert_top.sv
module lim_alert_top
  import lac_pkg::*;
#(
  parameter int N_VOLT = 4,
  parameter int N_TEMP = 3,
  parameter int N_FAN  = 2,
  parameter int VOLT_W = 8,
  parameter int TEMP_W = 8,
  parameter int FAN_W  = 16,
  parameter int DW     = 16,
  parameter int NCH    = N_VOLT + N_TEMP + N_FAN,
  parameter int CHW    = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           meas_vld_i,
  input  logic [CHW-1:0] meas_ch_i,
  input  logic [DW-1:0]  meas_val_i,
  input  logic           lim_wr_i,
  input  logic [CHW-1:0] lim_ch_i,
  input  logic           lim_hi_i,
  input  logic [DW-1:0]  lim_val_i,
  input  logic           msk_wr_i,
  input  logic [NCH-1:0] msk_val_i,
  input  logic           stat_rd_i,
  output logic [NCH-1:0] status_o,
  output logic           alert_pull_o
);

  logic [DW-1:0]  sel_hi;
  logic [DW-1:0]  sel_lo;
  logic           oor;
  logic           ch_ok;
  logic           vld_ok;
  chan_kind_e     meas_kind;
  logic [NCH-1:0] fault_vec;

  assign ch_ok  = (int'(meas_ch_i) < NCH);
  assign vld_ok = meas_vld_i && ch_ok;

  always_comb begin
    meas_kind = KIND_VOLT;
    for (int c = 0; c < NCH; c++) begin
      if (meas_ch_i == CHW'(c)) meas_kind = kind_of(c, N_VOLT, N_TEMP);
    end
  end

  lac_limits #(
    .N_VOLT(N_VOLT), .N_TEMP(N_TEMP), .N_FAN(N_FAN),
    .VOLT_W(VOLT_W), .TEMP_W(TEMP_W), .FAN_W(FAN_W),
    .DW(DW), .NCH(NCH), .CHW(CHW)
  ) u_limits (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (lim_wr_i),
    .wr_ch_i  (lim_ch_i),
    .wr_hi_i  (lim_hi_i),
    .wr_val_i (lim_val_i),
    .sel_ch_i (meas_ch_i),
    .hi_o     (sel_hi),
    .lo_o     (sel_lo)
  );

  lac_compare #(
    .VOLT_W(VOLT_W), .TEMP_W(TEMP_W), .FAN_W(FAN_W), .DW(DW)
  ) u_compare (
    .kind_i (meas_kind),
    .val_i  (meas_val_i),
    .hi_i   (sel_hi),
    .lo_i   (sel_lo),
    .oor_o  (oor)
  );

  lac_status #(
    .NCH(NCH), .CHW(CHW)
  ) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .meas_vld_i (vld_ok),
    .meas_ch_i  (meas_ch_i),
    .oor_i      (oor),
    .rd_i       (stat_rd_i),
    .msk_wr_i   (msk_wr_i),
    .msk_val_i  (msk_val_i),
    .status_o   (status_o),
    .fault_o    (fault_vec),
    .alert_o    (alert_pull_o)
  );

endmodule

// File: rtl/lim_alert_chk.sv
module lim_alert_chk #(
  parameter int NCH = 9,
  parameter int CHW = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           meas_vld_i,
  input logic [CHW-1:0] meas_ch_i,
  input logic           stat_rd_i,
  input logic [NCH-1:0] status_o,
  input logic [NCH-1:0] fault_vec,
  input logic           alert_pull_o
);

  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_rd_i |=> ((status_o & $past(status_o)) == $past(status_o)));

  assert_read_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !meas_vld_i) |=> ((status_o & ~$past(fault_vec)) == '0));

  assert_alert_needs_status_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_pull_o |-> (status_o != '0));

  assert_fault_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !meas_vld_i |=> ((status_o & $past(status_o & fault_vec)) == $past(status_o & fault_vec)));

  assert_bad_channel_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_vld_i && (int'(meas_ch_i) >= NCH) && !stat_rd_i) |=> (status_o == $past(status_o)));

endmodule

bind lim_alert_top lim_alert_chk #(.NCH(NCH), .CHW(CHW)) u_lim_alert_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .meas_vld_i   (meas_vld_i),
  .meas_ch_i    (meas_ch_i),
  .stat_rd_i    (stat_rd_i),
  .status_o     (status_o),
  .fault_vec    (fault_vec),
  .alert_pull_o (alert_pull_o)
);

// File: tb/test_lim_alert_top.sv
module test_lim_alert_top;

  localparam int NCH = 9;
  localparam int CHW = 4;
  localparam int DW  = 16;
  localparam int NVEC = 17;

  logic           clk_i = 1'b0;
  logic           rst_ni;
  logic           meas_vld_i;
  logic [CHW-1:0] meas_ch_i;
  logic [DW-1:0]  meas_val_i;
  logic           lim_wr_i;
  logic [CHW-1:0] lim_ch_i;
  logic           lim_hi_i;
  logic [DW-1:0]  lim_val_i;
  logic           msk_wr_i;
  logic [NCH-1:0] msk_val_i;
  logic           stat_rd_i;
  logic [NCH-1:0] status_o;
  logic           alert_pull_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  lim_alert_top i_lim_alert_top (.*);

  // Vector: {ch[3:0], val[15:0], rd, exp_status[8:0], exp_alert}
  // Channels 0-3 voltage, 4-6 temperature, 7-8 fan.
  localparam logic [30:0] VEC [NVEC] = '{
    {4'd0, 16'h0050, 1'b0, 9'h000, 1'b0},  // R1 inside bounds
    {4'd0, 16'h00C1, 1'b0, 9'h001, 1'b1},  // R1 above high
    {4'd0, 16'h00C0, 1'b0, 9'h001, 1'b1},  // R5 sticky, equal to high
    {4'd1, 16'h003F, 1'b0, 9'h003, 1'b1},  // R1 below low
    {4'd1, 16'h0050, 1'b1, 9'h000, 1'b0},  // R6 read clears recovered bits
    {4'd4, 16'h0080, 1'b0, 9'h010, 1'b1},  // R4 -128 under default low
    {4'd5, 16'h0081, 1'b0, 9'h010, 1'b1},  // R4 equal to default low
    {4'd6, 16'h007F, 1'b0, 9'h010, 1'b1},  // R4 equal to default high
    {4'd5, 16'h00FF, 1'b0, 9'h010, 1'b1},  // R2 -1 inside bounds
    {4'd4, 16'h0000, 1'b1, 9'h000, 1'b0},  // R6
    {4'd7, 16'hFFFE, 1'b0, 9'h000, 1'b0},  // R3 under default bound
    {4'd7, 16'hFFFF, 1'b0, 9'h080, 1'b1},  // R3 stall flagged
    {4'd7, 16'hFFFF, 1'b1, 9'h080, 1'b1},  // R8 read during live fault
    {4'd7, 16'h1000, 1'b1, 9'h000, 1'b0},  // R6 recovered then read
    {4'd9, 16'hFFFF, 1'b0, 9'h000, 1'b0},  // R10 invalid channel
    {4'd6, 16'h0080, 1'b0, 9'h040, 1'b1},  // R2 signed low compare
    {4'd6, 16'h007E, 1'b1, 9'h000, 1'b0}   // R6
  };

  task automatic check(input string req, input logic [NCH-1:0] exp_s, input logic exp_a);
    n_chk++;
    if (status_o !== exp_s || alert_pull_o !== exp_a) begin
      n_fail++;
      $display("FAIL %s: status=%h alert=%b expected status=%h alert=%b",
               req, status_o, alert_pull_o, exp_s, exp_a);
    end
  endtask

  task automatic measure(input logic [CHW-1:0] ch, input logic [DW-1:0] val, input logic rd);
    @(negedge clk_i);
    meas_vld_i = 1'b1; meas_ch_i = ch; meas_val_i = val;
    @(negedge clk_i);
    meas_vld_i = 1'b0;
    if (rd) begin
      stat_rd_i = 1'b1;
      @(negedge clk_i);
      stat_rd_i = 1'b0;
    end
  endtask

  task automatic set_limit(input logic [CHW-1:0] ch, input logic hi, input logic [DW-1:0] val);
    @(negedge clk_i);
    lim_wr_i = 1'b1; lim_ch_i = ch; lim_hi_i = hi; lim_val_i = val;
    @(negedge clk_i);
    lim_wr_i = 1'b0;
  endtask

  task automatic set_mask(input logic [NCH-1:0] m);
    @(negedge clk_i);
    msk_wr_i = 1'b1; msk_val_i = m;
    @(negedge clk_i);
    msk_wr_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0;
    meas_vld_i = 1'b0; meas_ch_i = '0; meas_val_i = '0;
    lim_wr_i = 1'b0; lim_ch_i = '0; lim_hi_i = 1'b0; lim_val_i = '0;
    msk_wr_i = 1'b0; msk_val_i = '0; stat_rd_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R4 reset state", 9'h000, 1'b0);

    // R1: tighten the bounds of voltage channels 0 and 1.
    set_limit(4'd0, 1'b0, 16'h0040);
    set_limit(4'd0, 1'b1, 16'h00C0);
    set_limit(4'd1, 1'b0, 16'h0040);
    set_limit(4'd1, 1'b1, 16'h00C0);

    for (int i = 0; i < NVEC; i++) begin
      measure(VEC[i][30:27], VEC[i][26:11], VEC[i][10]);
      check($sformatf("vector %0d", i), VEC[i][9:1], VEC[i][0]);
    end

    // R2: signed compare against a small positive high bound.
    set_limit(4'd4, 1'b1, 16'h0010);
    measure(4'd4, 16'h00F0, 1'b0);
    check("R2 -16 below +16", 9'h000, 1'b0);
    measure(4'd4, 16'h0011, 1'b0);
    check("R2 +17 above +16", 9'h010, 1'b1);
    measure(4'd4, 16'h0000, 1'b1);
    check("R6 clear temp", 9'h000, 1'b0);

    // R9: a fan bound write reaches only its own channel.
    set_limit(4'd8, 1'b1, 16'h2000);
    measure(4'd7, 16'h2001, 1'b0);
    check("R9 other fan untouched", 9'h000, 1'b0);

    // R7: masked status does not raise the alert.
    set_mask(9'h100);
    check("R7 mask write keeps status", 9'h000, 1'b0);
    measure(4'd8, 16'h2001, 1'b0);
    check("R7 masked channel, R9 new bound", 9'h100, 1'b0);
    set_mask(9'h000);
    check("R7 unmasked raises alert", 9'h100, 1'b1);
    measure(4'd8, 16'h2000, 1'b1);
    check("R6 fan recovered read", 9'h000, 1'b0);

    // R8: two reads while a fault lasts.
    measure(4'd2, 16'h0000, 1'b0);
    check("R1 default volt low bound equal", 9'h000, 1'b0);
    set_limit(4'd2, 1'b1, 16'h0010);
    measure(4'd2, 16'h0011, 1'b1);
    check("R8 first read during fault", 9'h004, 1'b1);
    @(negedge clk_i); stat_rd_i = 1'b1;
    @(negedge clk_i); stat_rd_i = 1'b0;
    check("R8 second read during fault", 9'h004, 1'b1);
    measure(4'd2, 16'h0010, 1'b0);
    check("R5 recovered but unread", 9'h004, 1'b1);
    @(negedge clk_i); stat_rd_i = 1'b1;
    @(negedge clk_i); stat_rd_i = 1'b0;
    check("R6 read after recovery", 9'h000, 1'b0);

    finish_run();
  end

endmodule